// File: doc/BRIEF.md
# Packed fractional saturating multiplier

This block multiplies signed fixed-point fractions lane by lane in a single pipeline stage. One operand pair of `XLEN` bits (32 or 64) is split into 16-bit Q15 lanes, into 32-bit Q31 lanes, or used as a single scalar Q31 pair. Each lane forms its full signed product and rescales it to the lane's fraction format with an arithmetic right shift. An optional half-LSB bias is added before the shift, which gives round-to-nearest instead of truncation.

The only product that cannot be represented is the most negative fraction multiplied by itself. That lane is clamped to the largest positive fraction. The same event sets a sticky saturation flag, which stays set until software clears it. An execution stage issues one operation per valid cycle and receives the result, a valid strobe and an illegal-mode indication one cycle later.

Top module: `qmul_simd`

## Requirements
- R1: `result`, `illegalMode` and `outValid` are registered. `outValid` is high exactly in the cycle after a cycle with `inValid` high. `result` holds its value while `inValid` is low.
- R2: `mode[1:0]`=00 selects halfword lanes. Lane i uses operand bits [16i+15:16i] and writes the same result bits. There are XLEN/16 lanes. Each lane's result is bits [30:15] of the 32-bit signed product, which is an arithmetic shift right by 15.
- R3: `mode[2]`=1 selects rounding. Before the shift, 2^14 is added to a halfword product, or 2^30 to a word product. `mode[2]`=0 adds nothing.
- R4: A halfword lane whose two operands are both 0x8000 outputs 0x7FFF and counts as saturated.
- R5: `mode[1:0]`=01 selects two packed word lanes, at bits [31:0] and [63:32]. Each lane's result is its 64-bit signed product shifted arithmetically right by 31. A lane whose two operands are both 0x80000000 outputs 0x7FFFFFFF and counts as saturated.
- R6: `mode[1:0]`=10 selects the scalar mode. It uses only operand bits [31:0], with the same rules as one word lane, and upper operand bits have no effect. The 32-bit result is sign-extended to XLEN bits.
- R7: A legal operation in which any lane saturates sets `satSticky`, visible together with its `outValid`. Operations that do not saturate leave the flag set.
- R8: A cycle with `satClr` high clears `satSticky` at the next edge. If a saturating operation is accepted in the same cycle, the flag ends up set.
- R9: `mode[1:0]`=11 is illegal in any build, and so is `mode[1:0]`=01 when XLEN=32. An illegal operation produces `illegalMode`=1 together with `outValid`, a zero `result`, and no change to `satSticky`.
- R10: After reset, `outValid`, `illegalMode`, `satSticky` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation accepted this cycle |
| mode | input | 3 | [1:0] lane kind, [2] rounding enable |
| opA | input | XLEN | First packed operand |
| opB | input | XLEN | Second packed operand |
| satClr | input | 1 | Synchronous clear of the sticky flag |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | XLEN | Packed or sign-extended scalar result |
| illegalMode | output | 1 | Operation was an illegal mode |
| satSticky | output | 1 | Sticky saturation flag |

## Verification
The scoreboarded instance is built with XLEN=64. This build reaches four halfword lanes, both word lanes, and the sign extension of the scalar result into the upper word. A second instance, built with XLEN=32, is checked directly. Only that build can reject packed word mode as illegal, and it also shows the halfword and scalar modes working on a narrow register.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    KIND_HALF   = 2'b00,
    KIND_WORD   = 2'b01,
    KIND_SCALAR = 2'b10,
    KIND_RSVD   = 2'b11
  } laneKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic selHalf;
    logic selWord;
    logic selScalar;
    logic roundEn;
    logic illegal;
  } dpCtrl_t;

endpackage

// File: rtl/qmul_ctrl.sv
module qmul_ctrl
  import qmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] mode,
  input  logic       satClr,
  input  logic       satAny,
  output dpCtrl_t    strobes,
  output logic       outValid,
  output logic       illegalMode,
  output logic       satSticky
);

  localparam bit WordLanesOk = (XLEN >= 2 * WORD_W);

  laneKind_e kind;
  logic      illegalOp;
  logic      satHit;

  assign kind      = laneKind_e'(mode[1:0]);
  assign illegalOp = (kind == KIND_RSVD) || ((kind == KIND_WORD) && !WordLanesOk);

  always_comb begin
    strobes.capture   = inValid;
    strobes.selHalf   = !illegalOp && (kind == KIND_HALF);
    strobes.selWord   = !illegalOp && (kind == KIND_WORD);
    strobes.selScalar = !illegalOp && (kind == KIND_SCALAR);
    strobes.roundEn   = mode[2];
    strobes.illegal   = illegalOp;
  end

  assign satHit = inValid && !illegalOp && satAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      illegalMode <= 1'b0;
      satSticky   <= 1'b0;
    end else begin
      outValid    <= inValid;
      illegalMode <= inValid && illegalOp;
      if (satHit)      satSticky <= 1'b1;
      else if (satClr) satSticky <= 1'b0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R1
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (satSticky && !satClr) |=> satSticky);  // R7
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (satClr && !satHit) |=> !satSticky);  // R8
  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satSticky) |-> $past(inValid));  // R7

endmodule

// File: rtl/qmul_dp.sv
module qmul_dp
  import qmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         strobes,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            satAny,
  output logic [XLEN-1:0] result
);

  localparam int NumHalf = XLEN / HALF_W;
  localparam int NumWord = XLEN / WORD_W;
  localparam logic signed [2*HALF_W-1:0] HalfBias = 1 <<< (HALF_W - 2);
  localparam logic signed [2*WORD_W-1:0] WordBias = 64'sd1 <<< (WORD_W - 2);

  logic [XLEN-1:0]    halfRes;
  logic [XLEN-1:0]    wordRes;
  logic [NumHalf-1:0] halfSat;
  logic [NumWord-1:0] wordSat;
  logic [XLEN-1:0]    nextRes;

  for (genvar i = 0; i < NumHalf; i++) begin : gHalf
    logic signed [HALF_W-1:0]   a, b;
    logic signed [2*HALF_W-1:0] prod, biased;
    assign a          = opA[i*HALF_W +: HALF_W];
    assign b          = opB[i*HALF_W +: HALF_W];
    assign prod       = a * b;
    assign biased     = prod + (strobes.roundEn ? HalfBias : '0);
    assign halfSat[i] = (a == {1'b1, {(HALF_W-1){1'b0}}}) && (b == {1'b1, {(HALF_W-1){1'b0}}});
    assign halfRes[i*HALF_W +: HALF_W] =
      halfSat[i] ? {1'b0, {(HALF_W-1){1'b1}}} : biased[2*HALF_W-2 : HALF_W-1];
  end

  for (genvar j = 0; j < NumWord; j++) begin : gWord
    logic signed [WORD_W-1:0]   a, b;
    logic signed [2*WORD_W-1:0] prod, biased;
    assign a          = opA[j*WORD_W +: WORD_W];
    assign b          = opB[j*WORD_W +: WORD_W];
    assign prod       = a * b;
    assign biased     = prod + (strobes.roundEn ? WordBias : '0);
    assign wordSat[j] = (a == {1'b1, {(WORD_W-1){1'b0}}}) && (b == {1'b1, {(WORD_W-1){1'b0}}});
    assign wordRes[j*WORD_W +: WORD_W] =
      wordSat[j] ? {1'b0, {(WORD_W-1){1'b1}}} : biased[2*WORD_W-2 : WORD_W-1];
  end

  always_comb begin
    nextRes = '0;
    satAny  = 1'b0;
    if (strobes.selHalf) begin
      nextRes = halfRes;
      satAny  = |halfSat;
    end else if (strobes.selWord) begin
      nextRes = wordRes;
      satAny  = |wordSat;
    end else if (strobes.selScalar) begin
      nextRes = XLEN'($signed(wordRes[WORD_W-1:0]));
      satAny  = wordSat[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                result <= '0;
    else if (strobes.capture) result <= nextRes;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(result));  // R1

  if (XLEN > WORD_W) begin : gSignChk
    AST_SCALAR_SIGNEXT: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.capture && strobes.selScalar) |=>
        (result[XLEN-1:WORD_W] == {(XLEN-WORD_W){result[WORD_W-1]}}));  // R6
  end

endmodule

// File: rtl/qmul_simd.sv
module qmul_simd
  import qmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [2:0]      mode,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic            satClr,
  output logic            outValid,
  output logic [XLEN-1:0] result,
  output logic            illegalMode,
  output logic            satSticky
);

  dpCtrl_t strobes;
  logic    satAny;

  qmul_ctrl #(.XLEN(XLEN)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .satClr(satClr),
    .satAny(satAny), .strobes(strobes), .outValid(outValid),
    .illegalMode(illegalMode), .satSticky(satSticky)
  );

  qmul_dp #(.XLEN(XLEN)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .satAny(satAny), .result(result)
  );

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> (outValid && (result == '0)));  // R9

endmodule

// File: tb/sim_qmul_simd.sv
module sim_qmul_simd;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // 64-bit instance, scoreboarded
  logic        inValid = 1'b0, satClr = 1'b0;
  logic [2:0]  mode = '0;
  logic [63:0] opA = '0, opB = '0;
  logic        outValid, illegalMode, satSticky;
  logic [63:0] result;

  qmul_simd #(.XLEN(64)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .opA(opA), .opB(opB),
    .satClr(satClr), .outValid(outValid), .result(result),
    .illegalMode(illegalMode), .satSticky(satSticky)
  );

  // 32-bit instance, direct checks
  logic        inValid1 = 1'b0, satClr1 = 1'b0;
  logic [2:0]  mode1 = '0;
  logic [31:0] opA1 = '0, opB1 = '0;
  logic        outValid1, illegalMode1, satSticky1;
  logic [31:0] result1;

  qmul_simd #(.XLEN(32)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid1), .mode(mode1), .opA(opA1), .opB(opB1),
    .satClr(satClr1), .outValid(outValid1), .result(result1),
    .illegalMode(illegalMode1), .satSticky(satSticky1)
  );

  typedef struct {
    logic [63:0] res;
    logic        ill;
    logic        stk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nChecks = 0;
  int   nFails = 0;
  logic stkModel = 1'b0;
  bit   done = 1'b0;

  // spec model: mode[1:0] kind, mode[2] rounding
  function automatic logic [63:0] model(input logic [2:0] md, input logic [63:0] a,
                                        input logic [63:0] b, input int xl,
                                        output logic sat, output logic ill);
    logic [63:0] r;
    logic signed [63:0] p;
    shortint x, y;
    int xw, yw;
    r = '0; sat = 1'b0;
    ill = (md[1:0] == 2'b11) || (md[1:0] == 2'b01 && xl == 32);
    if (ill) return '0;
    if (md[1:0] == 2'b00) begin
      for (int i = 0; i < xl / 16; i++) begin
        x = a[i*16 +: 16]; y = b[i*16 +: 16];
        if (x == -32768 && y == -32768) begin
          r[i*16 +: 16] = 16'h7FFF; sat = 1'b1;
        end else begin
          p = longint'(x) * longint'(y) + (md[2] ? 64'sd16384 : 64'sd0);
          r[i*16 +: 16] = p[30:15];
        end
      end
    end else begin
      for (int j = 0; j < ((md[1:0] == 2'b01) ? 2 : 1); j++) begin
        xw = a[j*32 +: 32]; yw = b[j*32 +: 32];
        if (xw == 32'h80000000 && yw == 32'h80000000) begin
          r[j*32 +: 32] = 32'h7FFFFFFF; sat = 1'b1;
        end else begin
          p = longint'(xw) * longint'(yw) + (md[2] ? 64'sd1073741824 : 64'sd0);
          r[j*32 +: 32] = p[62:31];
        end
      end
      if (md[1:0] == 2'b10) r[63:32] = {32{r[31]}};
    end
    if (xl == 32) r[63:32] = '0;
    return r;
  endfunction

  task automatic check(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic applyOp(input logic [2:0] md, input logic [63:0] a, input logic [63:0] b,
                         input logic clr, input string tag);
    exp_t e;
    logic sat, ill;
    @(negedge clk);
    inValid = 1'b1; mode = md; opA = a; opB = b; satClr = clr;
    e.res = model(md, a, b, 64, sat, ill);
    e.ill = ill;
    stkModel = (!ill && sat) ? 1'b1 : (clr ? 1'b0 : stkModel);
    e.stk = stkModel;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0; satClr = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 outValid with no pending operation: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result == e.res && illegalMode == e.ill && satSticky == e.stk,
              $sformatf("%s result %h/ill %0b/stk %0b expected %h/%0b/%0b",
                        e.tag, result, illegalMode, satSticky, e.res, e.ill, e.stk));
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    logic [63:0] held;
    logic sat, ill;
    logic [63:0] e1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!outValid && !illegalMode && !satSticky && result == '0,
          $sformatf("R10 reset outputs v%0b i%0b s%0b r%h expected all zero",
                    outValid, illegalMode, satSticky, result));

    applyOp(3'b000, 64'h4000_2000_C000_7FFF, 64'h4000_4000_4000_7FFF, 1'b0, "R2 half trunc");
    applyOp(3'b100, 64'h0003_FFFF_1234_8001, 64'h4001_0001_5678_7FFF, 1'b0, "R3 half round");
    applyOp(3'b000, 64'h0003_FFFF_1234_8001, 64'h4001_0001_5678_7FFF, 1'b0, "R2 half trunc neg");
    applyOp(3'b000, 64'h8000_8000_0001_8000, 64'h8000_7FFF_8000_8000, 1'b0, "R4 R7 half corner");
    applyOp(3'b001, 64'h4000_0000_C000_0001, 64'h2000_0000_4000_0003, 1'b0, "R5 R7 word trunc holds sticky");
    idle(1);
    @(negedge clk);
    satClr = 1'b1;
    stkModel = 1'b0;
    @(negedge clk);
    satClr = 1'b0;
    check(satSticky == 1'b0, $sformatf("R8 clear actual %0b expected 0", satSticky));

    applyOp(3'b101, 64'h0000_0003_8000_0001, 64'h4000_0001_7FFF_FFFF, 1'b0, "R3 word round");
    applyOp(3'b001, 64'h0000_0003_8000_0001, 64'h4000_0001_7FFF_FFFF, 1'b0, "R5 word trunc");
    applyOp(3'b001, 64'h8000_0000_1234_5678, 64'h8000_0000_0001_0000, 1'b0, "R5 word corner");
    applyOp(3'b000, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 1'b1, "R8 set wins over clear");
    applyOp(3'b000, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000, 1'b1, "R8 clear with op");
    applyOp(3'b010, 64'hDEAD_BEEF_C000_0000, 64'hFFFF_0000_4000_0000, 1'b0, "R6 scalar signext");
    applyOp(3'b010, 64'h0000_0000_C000_0000, 64'h0000_0000_4000_0000, 1'b0, "R6 scalar upper ignored");
    applyOp(3'b110, 64'h1234_5678_0000_0003, 64'h9ABC_DEF0_4000_0001, 1'b0, "R3 R6 scalar round");
    applyOp(3'b010, 64'h5555_5555_8000_0000, 64'hAAAA_AAAA_8000_0000, 1'b0, "R6 scalar corner");
    applyOp(3'b000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b1, "R8 clear");
    applyOp(3'b011, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1'b0, "R9 reserved mode");
    applyOp(3'b111, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0, "R9 reserved round");
    idle(2);
    held = result;
    repeat (3) @(negedge clk);
    check(!outValid && result == held,
          $sformatf("R1 idle hold v%0b r%h expected 0/%h", outValid, result, held));

    for (int k = 0; k < 60; k++) begin
      logic [2:0] md;
      md = {1'($urandom), 2'($urandom % 3)};
      applyOp(md, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom % 5 == 0),
              "R2 R3 R5 R6 random");
    end
    idle(3);

    // 32-bit build
    @(negedge clk);
    inValid1 = 1'b1; mode1 = 3'b001; opA1 = 32'h8000_0000; opB1 = 32'h8000_0000;
    @(negedge clk);
    inValid1 = 1'b0;
    check(outValid1 && illegalMode1 && result1 == '0 && !satSticky1,
          $sformatf("R9 narrow word mode v%0b i%0b r%h s%0b expected 1/1/0/0",
                    outValid1, illegalMode1, result1, satSticky1));
    inValid1 = 1'b1; mode1 = 3'b000; opA1 = 32'h8000_C000; opB1 = 32'h8000_4000;
    e1 = model(3'b000, 64'(opA1), 64'(opB1), 32, sat, ill);
    @(negedge clk);
    inValid1 = 1'b0;
    check(outValid1 && !illegalMode1 && result1 == e1[31:0] && satSticky1,
          $sformatf("R2 R4 narrow half r%h s%0b expected %h/1", result1, satSticky1, e1[31:0]));
    inValid1 = 1'b1; mode1 = 3'b110; opA1 = 32'hC000_0001; opB1 = 32'h4000_0003;
    e1 = model(3'b110, 64'(opA1), 64'(opB1), 32, sat, ill);
    @(negedge clk);
    inValid1 = 1'b0;
    check(outValid1 && result1 == e1[31:0],
          $sformatf("R6 narrow scalar r%h expected %h", result1, e1[31:0]));

    repeat (2) @(negedge clk);
    check(q.size() == 0, $sformatf("R1 pending results %0d expected 0", q.size()));
    done = 1'b1;
    summary();
  end

endmodule